// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches sixteen external interrupt lines and keeps one sticky status flag per line. Each line has a two-bit sense mode: low level, falling edge, rising edge or both edges. When a line meets its sense condition, its flag is set. A flag stays set until software writes a zero to its bit in the status register. The request output for a line is high while both its flag and its enable bit are set. A downstream arbiter consumes these outputs; arbitration, vectoring and CPU handshaking are not part of this block.

Every input pin passes through a two-flop synchronizer before detection. Lines 7 to 15 can each take their input from a primary pin or from an alternate pin. For line 6, the vector-mode bit makes that choice.

When the vector-mode bit is 0 (compatibility mode), sixteen active-low key inputs are merged onto two lines. Each key input is first gated by its own mask bit. Keys 0 to 7 feed line 6 and keys 8 to 15 feed line 7. Detection does not depend on any port direction setting.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset: enable register 0000, status 0000, both mode registers 0000, alternate-select 0000, key mask FFFF, configuration 0000, and all request outputs are low.
- R2: `req_o[n]` is high exactly when status flag n and enable bit n (register address 0) are both set.
- R3: The status register (address 1) holds each flag until cleared. Writing 0 to a bit clears that flag. Writing 1 to a bit has no effect.
- R4: Line n's sense mode sits at bits 2(n mod 8)+1 : 2(n mod 8). Lines 0–7 use address 2 and lines 8–15 use address 3. Mode 00 sets the flag on every cycle in which the synchronized line is low.
- R5: Mode 01 sets the flag on a high-to-low transition of the synchronized line. Holding the line low sets nothing further.
- R6: Mode 10 sets the flag on a low-to-high transition only.
- R7: Mode 11 sets the flag on either transition.
- R8: A pin change is sampled at a rising edge. The flag becomes visible after the third rising edge counted from that sample edge, and not after the second.
- R9: The alternate-select register is at address 4. Bit n, for n from 7 to 15, routes line n from its alternate pin instead of its primary pin. Bits 0–6 read as 0, and writing them has no effect.
- R10: Bit 0 of address 6 is the vector-mode bit. When it is 1, line 6 follows alternate pin 6. When it is 0, line 6 follows primary pin 6.
- R11: With vector mode 0, line 6 is additionally pulled low when any unmasked key input 0–7 is low, and line 7 when any unmasked key input 8–15 is low. A key mask bit (address 5) set to 1 blocks its key.
- R12: With vector mode 1, key inputs have no effect on any line.
- R13: If a zero is written to a flag in the same cycle that a sense event for that line occurs, the flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 16 | Primary interrupt pins, idle high |
| irq_alt_i | input | 10 | Alternate pins for lines 6 to 15 (bit index = line) |
| key_n_i | input | 16 | Active-low key-sense inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` (combinational) |
| req_o | output | 16 | Per-line interrupt requests |

## Verification
The bench targets the timing where the sticky flag meets the clear write. A design in which the clear wins would drop an event that arrives in the same cycle as a clear (R13). A design that lets a written 1 set flags would raise spurious requests (R3).

It counts synchronizer stages exactly. An extra or missing flop shifts the flag by a cycle and trips the R8 check.

Edge modes are driven with held levels, so a level-style detector would keep re-setting a cleared flag. Line 6 and line 7 sources are exercised in both vector modes with masked and unmasked keys. A mux that ignores the mode bit or the mask polarity would set or miss flags there.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;
  localparam int unsigned NLINE     = 16;
  localparam int unsigned NKEY      = 16;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned SYNC_N    = 2;
  localparam int unsigned KEY_LINE_LO = 6;   // merged key group 0 lands here
  localparam int unsigned KEY_LINE_HI = 7;   // merged key group 1 lands here
  localparam int unsigned ALT_BASE  = KEY_LINE_LO;
  localparam int unsigned ALT_FIRST = KEY_LINE_HI;
  localparam int unsigned NSEL      = NLINE - ALT_FIRST;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  typedef enum logic [ADDR_W-1:0] {
    A_EN      = 3'd0,
    A_STAT    = 3'd1,
    A_MODE_LO = 3'd2,
    A_MODE_HI = 3'd3,
    A_ALT     = 3'd4,
    A_KMASK   = 3'd5,
    A_CFG     = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '1;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/irq_src_mux.sv
`timescale 1ns/1ps
module irq_src_mux
  import ext_irq_pkg::*;
(
  input  logic [NLINE-1:0]          pin_i,
  input  logic [NLINE-1:ALT_BASE]   alt_i,
  input  logic [NKEY-1:0]           key_i,
  input  logic [NLINE-1:ALT_FIRST]  alt_sel_i,
  input  logic [NKEY-1:0]           kmask_i,
  input  logic                      vmode_i,
  output logic [NLINE-1:0]          line_o
);
  localparam int unsigned KHALF = NKEY / 2;

  logic key_lo_n, key_hi_n;
  // low when any unmasked key is low
  assign key_lo_n = &(key_i[KHALF-1:0]    | kmask_i[KHALF-1:0]);
  assign key_hi_n = &(key_i[NKEY-1:KHALF] | kmask_i[NKEY-1:KHALF]);

  for (genvar n = 0; n < NLINE; n++) begin : g_line
    if (n < ALT_BASE) begin : g_plain
      assign line_o[n] = pin_i[n];
    end else if (n < ALT_FIRST) begin : g_vsel
      assign line_o[n] = vmode_i ? alt_i[n] : (pin_i[n] & key_lo_n);
    end else if (n == ALT_FIRST) begin : g_key_hi
      logic pick;
      assign pick      = alt_sel_i[n] ? alt_i[n] : pin_i[n];
      assign line_o[n] = pick & (vmode_i | key_hi_n);
    end else begin : g_alt
      assign line_o[n] = alt_sel_i[n] ? alt_i[n] : pin_i[n];
    end
  end
endmodule

// File: rtl/irq_sense.sv
`timescale 1ns/1ps
module irq_sense
  import ext_irq_pkg::*;
#(
  parameter int unsigned N = NLINE
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   line_i,
  input  logic [2*N-1:0] mode_i,
  input  logic [N-1:0]   clr_i,
  output logic [N-1:0]   hit_o,
  output logic [N-1:0]   flag_o
);
  logic [N-1:0] prev_q, flag_q;

  for (genvar n = 0; n < N; n++) begin : g_det
    sense_e md;
    assign md = sense_e'(mode_i[2*n +: 2]);
    always_comb begin
      unique case (md)
        SENSE_LOW:  hit_o[n] = ~line_i[n];
        SENSE_FALL: hit_o[n] = prev_q[n] & ~line_i[n];
        SENSE_RISE: hit_o[n] = ~prev_q[n] & line_i[n];
        default:    hit_o[n] = prev_q[n] ^ line_i[n];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      flag_q <= '0;
    end else begin
      prev_q <= line_i;
      flag_q <= hit_o | (flag_q & ~clr_i);  // set beats clear
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
  import ext_irq_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [NLINE-1:0]         flag_i,
  output logic [NLINE-1:0]         en_o,
  output logic [2*NLINE-1:0]       mode_o,
  output logic [NLINE-1:ALT_FIRST] alt_sel_o,
  output logic [NKEY-1:0]          kmask_o,
  output logic                     vmode_o,
  output logic [NLINE-1:0]         clr_o,
  output logic [DATA_W-1:0]        rdata_o
);
  logic [NLINE-1:0]         en_q;
  logic [2*NLINE-1:0]       mode_q;
  logic [NLINE-1:ALT_FIRST] alt_q;
  logic [NKEY-1:0]          kmask_q;
  logic                     vmode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      mode_q  <= '0;
      alt_q   <= '0;
      kmask_q <= '1;
      vmode_q <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        A_EN:      en_q              <= wdata_i;
        A_MODE_LO: mode_q[DATA_W-1:0] <= wdata_i;
        A_MODE_HI: mode_q[2*DATA_W-1:DATA_W] <= wdata_i;
        A_ALT:     alt_q             <= wdata_i[NLINE-1:ALT_FIRST];
        A_KMASK:   kmask_q           <= wdata_i;
        A_CFG:     vmode_q           <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && addr_i == A_STAT) ? ~wdata_i : '0;

  always_comb begin
    case (addr_i)
      A_EN:      rdata_o = en_q;
      A_STAT:    rdata_o = flag_i;
      A_MODE_LO: rdata_o = mode_q[DATA_W-1:0];
      A_MODE_HI: rdata_o = mode_q[2*DATA_W-1:DATA_W];
      A_ALT:     rdata_o = {alt_q, {ALT_FIRST{1'b0}}};
      A_KMASK:   rdata_o = kmask_q;
      A_CFG:     rdata_o = {{(DATA_W-1){1'b0}}, vmode_q};
      default:   rdata_o = '0;
    endcase
  end

  assign en_o      = en_q;
  assign mode_o    = mode_q;
  assign alt_sel_o = alt_q;
  assign kmask_o   = kmask_q;
  assign vmode_o   = vmode_q;
endmodule

// File: rtl/ext_irq_detect.sv
`timescale 1ns/1ps
module ext_irq_detect
  import ext_irq_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NLINE-1:0]        irq_pin_i,
  input  logic [NLINE-1:ALT_BASE] irq_alt_i,
  input  logic [NKEY-1:0]         key_n_i,
  input  logic                    reg_we_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  output logic [NLINE-1:0]        req_o
);
  localparam int unsigned NALT = NLINE - ALT_BASE;

  logic [NLINE-1:0]         pin_s, line_s, hit_w, flag_w, en_w, clr_w;
  logic [NLINE-1:ALT_BASE]  alt_s;
  logic [NKEY-1:0]          key_s, kmask_w;
  logic [2*NLINE-1:0]       mode_w;
  logic [NLINE-1:ALT_FIRST] alt_sel_w;
  logic                     vmode_w;

  irq_sync #(.W(NLINE), .STAGES(SYNC_N)) u_sync_pin (
    .clk_i, .rst_ni, .d_i(irq_pin_i), .q_o(pin_s));
  irq_sync #(.W(NALT), .STAGES(SYNC_N)) u_sync_alt (
    .clk_i, .rst_ni, .d_i(irq_alt_i), .q_o(alt_s));
  irq_sync #(.W(NKEY), .STAGES(SYNC_N)) u_sync_key (
    .clk_i, .rst_ni, .d_i(key_n_i), .q_o(key_s));

  irq_src_mux u_mux (
    .pin_i(pin_s), .alt_i(alt_s), .key_i(key_s), .alt_sel_i(alt_sel_w),
    .kmask_i(kmask_w), .vmode_i(vmode_w), .line_o(line_s));

  irq_sense #(.N(NLINE)) u_sense (
    .clk_i, .rst_ni, .line_i(line_s), .mode_i(mode_w), .clr_i(clr_w),
    .hit_o(hit_w), .flag_o(flag_w));

  irq_regs u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .flag_i(flag_w), .en_o(en_w), .mode_o(mode_w), .alt_sel_o(alt_sel_w),
    .kmask_o(kmask_w), .vmode_o(vmode_w), .clr_o(clr_w), .rdata_o(reg_rdata_o));

  assign req_o = flag_w & en_w;
endmodule

// File: rtl/ext_irq_chk.sv
`timescale 1ns/1ps
module ext_irq_chk
  import ext_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic [NLINE-1:0]   req_o,
  input logic [NLINE-1:0]   flag_i,
  input logic [NLINE-1:0]   hit_i,
  input logic [NLINE-1:0]   clr_i,
  input logic [NLINE-1:0]   line_i,
  input logic [2*NLINE-1:0] mode_i
);
  AST_REQ_OFF_AFTER_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_EN) |=> ((req_o & ~$past(reg_wdata_i)) == '0)); // R2

  for (genvar n = 0; n < NLINE; n++) begin : g_ln
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[n] && !clr_i[n]) |=> flag_i[n]); // R3
    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[n] && clr_i[n] && !hit_i[n]) |=> !flag_i[n]); // R3
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i[n] && clr_i[n]) |=> flag_i[n]); // R13
    AST_LEVEL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[2*n +: 2] == 2'b00 && !line_i[n]) |=> flag_i[n]); // R4
  end
endmodule

bind ext_irq_detect ext_irq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .req_o(req_o), .flag_i(flag_w), .hit_i(hit_w),
  .clr_i(clr_w), .line_i(line_s), .mode_i(mode_w));

// File: tb/ext_irq_detect_tb_top.sv
`timescale 1ns/1ps
module ext_irq_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin = 16'hFFFF;
  logic [15:6] alt = 10'h3FF;
  logic [15:0] key = 16'hFFFF;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd1;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata, req;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  ext_irq_detect dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pin), .irq_alt_i(alt), .key_n_i(key),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .req_o(req));

  // reference model
  logic [15:0] m_en, m_flag, m_alt, m_kmask, m_prev;
  logic [31:0] m_mode;
  logic        m_vmode;
  logic [15:0] pq[$], kq[$];
  logic [15:6] aq[$];

  function automatic logic [15:0] m_line(input logic [15:0] p, input logic [15:6] a,
                                         input logic [15:0] k);
    logic [15:0] r;
    logic lo_any, hi_any;
    lo_any = 1'b0; hi_any = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (!m_kmask[i] && !k[i]) begin
        if (i < 8) lo_any = 1'b1; else hi_any = 1'b1;
      end
    end
    for (int i = 0; i < 16; i++) begin
      if (i < 6) r[i] = p[i];
      else if (i == 6) r[i] = m_vmode ? a[6] : (p[6] && !lo_any);
      else begin
        r[i] = m_alt[i] ? a[i] : p[i];
        if (i == 7 && !m_vmode && hi_any) r[i] = 1'b0;
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_en;
      3'd1: return m_flag;
      3'd2: return m_mode[15:0];
      3'd3: return m_mode[31:16];
      3'd4: return m_alt;
      3'd5: return m_kmask;
      3'd6: return {15'd0, m_vmode};
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_flag = 0; m_alt = 0; m_kmask = 16'hFFFF; m_mode = 0; m_vmode = 0;
      m_prev = 16'hFFFF;
      pq = {16'hFFFF, 16'hFFFF}; aq = {10'h3FF, 10'h3FF}; kq = {16'hFFFF, 16'hFFFF};
    end else begin
      logic [15:0] cur, hit, clr;
      cur = m_line(pq[0], aq[0], kq[0]);
      for (int i = 0; i < 16; i++) begin
        case (m_mode[2*i +: 2])
          2'b00: hit[i] = !cur[i];
          2'b01: hit[i] = m_prev[i] && !cur[i];
          2'b10: hit[i] = !m_prev[i] && cur[i];
          default: hit[i] = m_prev[i] != cur[i];
        endcase
      end
      clr = (we && addr == 3'd1) ? ~wdata : 16'h0;
      m_flag = hit | (m_flag & ~clr);
      m_prev = cur;
      if (we) case (addr)
        3'd0: m_en = wdata;
        3'd2: m_mode[15:0] = wdata;
        3'd3: m_mode[31:16] = wdata;
        3'd4: m_alt = wdata & 16'hFF80;
        3'd5: m_kmask = wdata;
        3'd6: m_vmode = wdata[0];
        default: ;
      endcase
      pq.push_back(pin); aq.push_back(alt); kq.push_back(key);
      void'(pq.pop_front()); void'(aq.pop_front()); void'(kq.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk("R2 model req", req, m_flag & m_en);
      chk("R3 model read", rdata, m_read(addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = 3'd1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #6; v = rdata;
    @(negedge clk); addr = 3'd1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [15:0] v;
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    chk("R1 req", req, 16'h0);
    rd(3'd0, v); chk("R1 en", v, 16'h0);
    rd(3'd1, v); chk("R1 stat", v, 16'h0);
    rd(3'd2, v); chk("R1 mode_lo", v, 16'h0);
    rd(3'd3, v); chk("R1 mode_hi", v, 16'h0);
    rd(3'd4, v); chk("R1 alt", v, 16'h0);
    rd(3'd5, v); chk("R1 kmask", v, 16'hFFFF);
    rd(3'd6, v); chk("R1 cfg", v, 16'h0);

    wr(3'd0, 16'hFFFF);
    wr(3'd2, 16'h00E4);   // line1 fall, line2 rise, line3 both
    wr(3'd3, 16'h0004);   // line9 fall

    // R4 level
    @(negedge clk) pin[0] = 0; idle(4);
    rd(3'd1, v); chk("R4 level set", v, 16'h0001);
    chk("R2 req follows flag", req, 16'h0001);
    @(negedge clk) pin[0] = 1; idle(4);
    rd(3'd1, v); chk("R3 sticky", v, 16'h0001);
    wr(3'd1, 16'hFFFF); rd(3'd1, v); chk("R3 write one noop", v, 16'h0001);
    wr(3'd1, 16'hFFFE); rd(3'd1, v); chk("R3 write zero clears", v, 16'h0);

    // R5 falling
    @(negedge clk) pin[1] = 0; idle(4);
    rd(3'd1, v); chk("R5 fall set", v, 16'h0002);
    wr(3'd1, 16'h0); idle(3);
    rd(3'd1, v); chk("R5 held low no reset", v, 16'h0);
    @(negedge clk) pin[1] = 1; idle(4);
    rd(3'd1, v); chk("R5 rise ignored", v, 16'h0);
    // R6 rising
    @(negedge clk) pin[2] = 0; idle(4);
    rd(3'd1, v); chk("R6 fall ignored", v, 16'h0);
    @(negedge clk) pin[2] = 1; idle(4);
    rd(3'd1, v); chk("R6 rise set", v, 16'h0004);
    wr(3'd1, 16'h0);
    // R7 both
    @(negedge clk) pin[3] = 0; idle(4);
    rd(3'd1, v); chk("R7 fall set", v, 16'h0008);
    wr(3'd1, 16'h0);
    @(negedge clk) pin[3] = 1; idle(4);
    rd(3'd1, v); chk("R7 rise set", v, 16'h0008);
    wr(3'd1, 16'h0);

    // R8 latency
    @(negedge clk) begin addr = 3'd1; pin[5] = 0; end
    @(negedge clk); @(negedge clk); #6;
    chk("R8 not after two edges", rdata & 16'h0020, 16'h0);
    @(negedge clk); #6;
    chk("R8 set after third edge", rdata & 16'h0020, 16'h0020);
    @(negedge clk) pin[5] = 1; idle(3); wr(3'd1, 16'h0);

    // R9 alternate select
    wr(3'd4, 16'hFFFF); rd(3'd4, v); chk("R9 low bits read zero", v, 16'hFF80);
    wr(3'd4, 16'h0208); idle(3);
    @(negedge clk) alt[9] = 0; idle(4);
    rd(3'd1, v); chk("R9 alt pin drives line9", v, 16'h0200);
    @(negedge clk) alt[9] = 1; idle(3); wr(3'd1, 16'h0);
    @(negedge clk) pin[9] = 0; idle(4);
    rd(3'd1, v); chk("R9 primary ignored when alt", v, 16'h0);
    @(negedge clk) pin[3] = 0; idle(4);
    rd(3'd1, v); chk("R9 bit3 select ignored", v, 16'h0008);
    @(negedge clk) begin pin[3] = 1; pin[9] = 1; end
    wr(3'd4, 16'h0); idle(3); wr(3'd1, 16'h0);

    // R10 line 6 source
    wr(3'd6, 16'h0001); idle(3);
    @(negedge clk) pin[6] = 0; idle(4);
    rd(3'd1, v); chk("R10 primary ignored vmode1", v, 16'h0);
    @(negedge clk) begin pin[6] = 1; alt[6] = 0; end idle(4);
    rd(3'd1, v); chk("R10 alt6 vmode1", v, 16'h0040);
    @(negedge clk) alt[6] = 1; idle(3); wr(3'd1, 16'h0);
    wr(3'd6, 16'h0000); idle(3);
    @(negedge clk) pin[6] = 0; idle(4);
    rd(3'd1, v); chk("R10 primary vmode0", v, 16'h0040);
    @(negedge clk) pin[6] = 1; idle(3); wr(3'd1, 16'h0);

    // R11 key merge
    @(negedge clk) key[2] = 0; idle(4);
    rd(3'd1, v); chk("R11 masked key2", v, 16'h0);
    wr(3'd5, 16'hFFFB); idle(3);
    rd(3'd1, v); chk("R11 unmasked key2 line6", v, 16'h0040);
    @(negedge clk) key[2] = 1; idle(3); wr(3'd1, 16'h0);
    @(negedge clk) key[10] = 0; idle(4);
    rd(3'd1, v); chk("R11 masked key10", v, 16'h0);
    wr(3'd5, 16'hFBFB); idle(3);
    rd(3'd1, v); chk("R11 unmasked key10 line7", v, 16'h0080);
    @(negedge clk) key[10] = 1; idle(3); wr(3'd1, 16'h0);

    // R12 keys ignored in vector mode 1
    wr(3'd6, 16'h0001); idle(3);
    @(negedge clk) begin key[2] = 0; key[10] = 0; end idle(4);
    rd(3'd1, v); chk("R12 keys ignored", v, 16'h0);
    @(negedge clk) begin key[2] = 1; key[10] = 1; end idle(3);
    wr(3'd6, 16'h0000); idle(3); wr(3'd1, 16'h0);

    // R13 set beats clear
    @(negedge clk) pin[0] = 0; idle(4);
    wr(3'd1, 16'h0);
    rd(3'd1, v); chk("R13 set wins", v, 16'h0001);
    @(negedge clk) pin[0] = 1; idle(3); wr(3'd1, 16'h0);
    rd(3'd1, v); chk("R3 clear after release", v, 16'h0);

    // R2 enable gating
    wr(3'd0, 16'h0001);
    @(negedge clk) begin pin[0] = 0; pin[4] = 0; end idle(4);
    rd(3'd1, v); chk("R2 both flags", v, 16'h0011);
    chk("R2 req gated", req, 16'h0001);
    @(negedge clk) begin pin[0] = 1; pin[4] = 1; end idle(3);
    wr(3'd1, 16'h0); wr(3'd0, 16'hFFFF); idle(2);
    chk("R2 req clear", req, 16'h0);

    summary();
  end
endmodule